// File: doc/BRIEF.md
# Early Direct-Branch Redirect Checker

This block sits in the decode stage and examines up to `DECODE_W` instructions per cycle, lowest slot oldest. For each instruction that is both a direct and an unconditional control transfer, it compares the target computed at decode with the next PC that the fetch predictor chose. On a mismatch it produces a redirect record for fetch, marks younger instructions in the same group for squashing, and stops passing instructions on to rename after the offending one. It also flags an instruction that the predictor marked taken although it is not a control instruction.

A parameter selects branch-delay-slot behaviour. In that mode a mismatching branch normally lets the instruction after it (the delay slot) through first, even when that instruction arrives in a later cycle. The redirect then carries a squash sequence number one above the branch. A branch that was predicted taken and whose delay slot is conditional squashes at once instead. Three counters track resolved branches, target mispredicts and control mispredicts. All outputs are registered, one cycle after the inputs are sampled.

Top module: `brx_redirect_check`

## Requirements
- R1: After reset every output is zero: no forwarded or killed slots, no redirect, no error, and all counters cleared.
- R2: Only slots with the control, direct and unconditional flags all set are checked. Indirect or conditional control instructions pass through with no redirect, whatever their target and prediction.
- R3: A checked slot whose target differs from its predicted PC produces a redirect one cycle later. The redirect's done sequence number is the branch's. Its next PC is the target and its next-next PC is the target plus `INST_SZ`. Its taken bit is 1 exactly when the predicted PC differs from the branch PC plus `INST_SZ`.
- R4: `fwd_o` bit i (slot i) is set for valid slots in program order up to and including the instruction that triggers the redirect. No later slot in that cycle is forwarded. With no redirect, every valid slot is forwarded.
- R5: When a redirect is issued, `kill_o` bit i is set for each valid slot whose sequence number is greater than the squash sequence number. Without a redirect, `kill_o` is zero.
- R6: A valid slot with the predicted-taken flag set and the control flag clear is forwarded and raises `ctrl_err_o`. It causes a redirect to its PC plus `INST_SZ`, with done and squash sequence numbers equal to its own and the taken bit defined as in R3.
- R7: Without delay slots, a target mismatch squashes at the branch itself. With delay slots, the same happens when the branch was predicted taken and its conditional-delay-slot flag is set.
- R8: In delay-slot mode, any other mismatch lets the next valid instruction through, in the same cycle or a later one (a pending state is held across idle cycles). The redirect is issued together with that instruction, with squash sequence number equal to the branch's plus one.
- R9: `cnt_resolved_o` counts checked slots that are evaluated. `cnt_mispred_o` counts target mismatches when they are detected. `cnt_ctrl_o` counts control mispredicts. All three wrap at `CNT_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | DECODE_W | Slot holds an instruction |
| in_ctrl_i | input | DECODE_W | Slot is a control instruction |
| in_direct_i | input | DECODE_W | Target is PC-relative or absolute (direct) |
| in_uncond_i | input | DECODE_W | Transfer is unconditional |
| in_pred_taken_i | input | DECODE_W | Predictor marked the slot taken |
| in_cond_ds_i | input | DECODE_W | Branch has a conditional delay slot |
| in_pc_i | input | DECODE_W*PC_W | Slot PC |
| in_seq_i | input | DECODE_W*SEQ_W | Slot sequence number |
| in_tgt_i | input | DECODE_W*PC_W | Target computed at decode |
| in_pred_pc_i | input | DECODE_W*PC_W | Predicted next PC |
| fwd_o | output | DECODE_W | Slots passed on to rename |
| kill_o | output | DECODE_W | Slots to be squashed |
| redir_valid_o | output | 1 | Redirect record valid |
| redir_done_seq_o | output | SEQ_W | Sequence number of the redirecting instruction |
| redir_squash_seq_o | output | SEQ_W | Instructions above this are squashed |
| redir_pc_o | output | PC_W | Corrected next PC |
| redir_npc_o | output | PC_W | Corrected next-next PC |
| redir_taken_o | output | 1 | Redirecting instruction was taken |
| ctrl_err_o | output | 1 | Non-control instruction was predicted taken |
| cnt_resolved_o | output | CNT_W | Resolved branch count |
| cnt_mispred_o | output | CNT_W | Target mispredict count |
| cnt_ctrl_o | output | CNT_W | Control mispredict count |

## Verification
The checker covers several rules on every cycle. Forwarded and killed slots never overlap, and nothing is killed without a redirect. Only slots that were valid are forwarded. A control error always comes with a redirect. The squash sequence number equals the done number, or exceeds it by one in delay-slot mode only. The control-mispredict counter moves exactly when the error fires. Only the scenarios can show that the redirect fields, the position where forwarding stops and the kill mask are the right ones for a given group. The same holds for a delay-slot redirect deferred across an idle cycle, for an invalid slot acting as a gap, and for the resolved and mispredict counts.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef struct packed {
    logic ctrl;
    logic direct;
    logic uncond;
    logic pred_taken;
    logic cond_ds;
  } brx_flags_t;

  typedef struct packed {
    logic check;   // direct unconditional, valid
    logic mis;     // checked and target differs from prediction
    logic cerr;    // predicted taken but not control
    logic taken;   // predicted next pc is not the fall-through
    logic imm_sq;  // delay-slot mode: squash at the branch itself
  } brx_eval_t;
endpackage

// File: rtl/brx_slot_eval.sv
module brx_slot_eval
  import brx_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int INST_SZ = 4
) (
  input  logic             valid_i,
  input  brx_flags_t       flags_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  output brx_eval_t        ev_o
);
  logic [PC_W-1:0] fall_pc;
  assign fall_pc = pc_i + PC_W'(INST_SZ);

  always_comb begin
    ev_o.check  = valid_i & flags_i.ctrl & flags_i.direct & flags_i.uncond;
    ev_o.mis    = ev_o.check & (tgt_i != pred_pc_i);
    ev_o.cerr   = valid_i & flags_i.pred_taken & ~flags_i.ctrl;
    ev_o.taken  = (pred_pc_i != fall_pc);
    ev_o.imm_sq = flags_i.pred_taken & flags_i.cond_ds;
  end
endmodule

// File: rtl/brx_resolve.sv
module brx_resolve
  import brx_pkg::*;
#(
  parameter int   DECODE_W    = 4,
  parameter int   PC_W        = 32,
  parameter int   SEQ_W       = 16,
  parameter int   INST_SZ     = 4,
  parameter bit   DELAY_SLOT  = 1'b0,
  localparam int  NR_W        = $clog2(DECODE_W + 1)
) (
  input  logic [DECODE_W-1:0]             valid_i,
  input  brx_eval_t [DECODE_W-1:0]        ev_i,
  input  logic [DECODE_W-1:0][PC_W-1:0]   pc_i,
  input  logic [DECODE_W-1:0][PC_W-1:0]   tgt_i,
  input  logic [DECODE_W-1:0][SEQ_W-1:0]  seq_i,
  input  logic                            pend_v_i,
  input  logic [SEQ_W-1:0]                pend_done_i,
  input  logic [SEQ_W-1:0]                pend_sq_i,
  input  logic [PC_W-1:0]                 pend_tgt_i,
  input  logic                            pend_taken_i,
  output logic [DECODE_W-1:0]             fwd_o,
  output logic [DECODE_W-1:0]             kill_o,
  output logic                            rv_o,
  output logic                            cerr_o,
  output logic                            taken_o,
  output logic [SEQ_W-1:0]                done_o,
  output logic [SEQ_W-1:0]                sq_o,
  output logic [PC_W-1:0]                 rpc_o,
  output logic [PC_W-1:0]                 rnpc_o,
  output logic                            pend_v_o,
  output logic [SEQ_W-1:0]                pend_done_o,
  output logic [SEQ_W-1:0]                pend_sq_o,
  output logic [PC_W-1:0]                 pend_tgt_o,
  output logic                            pend_taken_o,
  output logic [NR_W-1:0]                 n_res_o,
  output logic                            mis_hit_o,
  output logic                            cerr_hit_o
);
  logic stop;

  always_comb begin
    fwd_o = '0; kill_o = '0;
    rv_o = 1'b0; cerr_o = 1'b0; taken_o = 1'b0;
    done_o = '0; sq_o = '0; rpc_o = '0; rnpc_o = '0;
    n_res_o = '0; mis_hit_o = 1'b0; cerr_hit_o = 1'b0;
    stop = 1'b0;
    pend_v_o = pend_v_i; pend_done_o = pend_done_i; pend_sq_o = pend_sq_i;
    pend_tgt_o = pend_tgt_i; pend_taken_o = pend_taken_i;
    for (int i = 0; i < DECODE_W; i++) begin
      if (!stop && valid_i[i]) begin
        fwd_o[i] = 1'b1;
        if (pend_v_o) begin
          // delay slot passes unchecked; deferred redirect goes with it
          rv_o = 1'b1; done_o = pend_done_o; sq_o = pend_sq_o;
          rpc_o = pend_tgt_o; taken_o = pend_taken_o;
          pend_v_o = 1'b0; stop = 1'b1;
        end else if (ev_i[i].cerr) begin
          cerr_hit_o = 1'b1; rv_o = 1'b1; cerr_o = 1'b1;
          done_o = seq_i[i]; sq_o = seq_i[i];
          rpc_o = pc_i[i] + PC_W'(INST_SZ); taken_o = ev_i[i].taken;
          stop = 1'b1;
        end else if (ev_i[i].check) begin
          n_res_o = n_res_o + 1'b1;
          if (ev_i[i].mis) begin
            mis_hit_o = 1'b1;
            if (!DELAY_SLOT || ev_i[i].imm_sq) begin
              rv_o = 1'b1; done_o = seq_i[i]; sq_o = seq_i[i];
              rpc_o = tgt_i[i]; taken_o = ev_i[i].taken;
              stop = 1'b1;
            end else begin
              pend_v_o = 1'b1; pend_done_o = seq_i[i];
              pend_sq_o = seq_i[i] + 1'b1;
              pend_tgt_o = tgt_i[i]; pend_taken_o = ev_i[i].taken;
            end
          end
        end
      end
    end
    if (rv_o) rnpc_o = rpc_o + PC_W'(INST_SZ);
    for (int i = 0; i < DECODE_W; i++)
      kill_o[i] = rv_o & valid_i[i] & (seq_i[i] > sq_o);
  end
endmodule

// File: rtl/brx_counters.sv
module brx_counters #(
  parameter int  CNT_W = 16,
  parameter int  NR_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NR_W-1:0]  n_res_i,
  input  logic             mis_hit_i,
  input  logic             cerr_hit_i,
  output logic [CNT_W-1:0] cnt_res_o,
  output logic [CNT_W-1:0] cnt_mis_o,
  output logic [CNT_W-1:0] cnt_ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_res_o  <= '0;
      cnt_mis_o  <= '0;
      cnt_ctrl_o <= '0;
    end else begin
      cnt_res_o  <= cnt_res_o + CNT_W'(n_res_i);
      cnt_mis_o  <= cnt_mis_o + CNT_W'(mis_hit_i);
      cnt_ctrl_o <= cnt_ctrl_o + CNT_W'(cerr_hit_i);
    end
  end
endmodule

// File: rtl/brx_redirect_check.sv
module brx_redirect_check
  import brx_pkg::*;
#(
  parameter int DECODE_W   = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INST_SZ    = 4,
  parameter int CNT_W      = 16,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [DECODE_W-1:0]             in_valid_i,
  input  logic [DECODE_W-1:0]             in_ctrl_i,
  input  logic [DECODE_W-1:0]             in_direct_i,
  input  logic [DECODE_W-1:0]             in_uncond_i,
  input  logic [DECODE_W-1:0]             in_pred_taken_i,
  input  logic [DECODE_W-1:0]             in_cond_ds_i,
  input  logic [DECODE_W-1:0][PC_W-1:0]   in_pc_i,
  input  logic [DECODE_W-1:0][SEQ_W-1:0]  in_seq_i,
  input  logic [DECODE_W-1:0][PC_W-1:0]   in_tgt_i,
  input  logic [DECODE_W-1:0][PC_W-1:0]   in_pred_pc_i,
  output logic [DECODE_W-1:0]             fwd_o,
  output logic [DECODE_W-1:0]             kill_o,
  output logic                            redir_valid_o,
  output logic [SEQ_W-1:0]                redir_done_seq_o,
  output logic [SEQ_W-1:0]                redir_squash_seq_o,
  output logic [PC_W-1:0]                 redir_pc_o,
  output logic [PC_W-1:0]                 redir_npc_o,
  output logic                            redir_taken_o,
  output logic                            ctrl_err_o,
  output logic [CNT_W-1:0]                cnt_resolved_o,
  output logic [CNT_W-1:0]                cnt_mispred_o,
  output logic [CNT_W-1:0]                cnt_ctrl_o
);
  localparam int NR_W = $clog2(DECODE_W + 1);

  brx_eval_t [DECODE_W-1:0] ev;

  for (genvar g = 0; g < DECODE_W; g++) begin : g_slot
    brx_flags_t fl;
    assign fl = '{ctrl: in_ctrl_i[g], direct: in_direct_i[g], uncond: in_uncond_i[g],
                  pred_taken: in_pred_taken_i[g], cond_ds: in_cond_ds_i[g]};
    brx_slot_eval #(.PC_W(PC_W), .INST_SZ(INST_SZ)) u_eval (
      .valid_i   (in_valid_i[g]),
      .flags_i   (fl),
      .pc_i      (in_pc_i[g]),
      .tgt_i     (in_tgt_i[g]),
      .pred_pc_i (in_pred_pc_i[g]),
      .ev_o      (ev[g])
    );
  end

  logic                pend_v_q, pend_v_d, pend_tk_q, pend_tk_d;
  logic [SEQ_W-1:0]    pend_done_q, pend_done_d, pend_sq_q, pend_sq_d;
  logic [PC_W-1:0]     pend_tgt_q, pend_tgt_d;
  logic [DECODE_W-1:0] fwd_d, kill_d;
  logic                rv_d, cerr_d, taken_d, mis_hit, cerr_hit;
  logic [SEQ_W-1:0]    done_d, sq_d;
  logic [PC_W-1:0]     rpc_d, rnpc_d;
  logic [NR_W-1:0]     n_res;

  brx_resolve #(
    .DECODE_W(DECODE_W), .PC_W(PC_W), .SEQ_W(SEQ_W),
    .INST_SZ(INST_SZ), .DELAY_SLOT(DELAY_SLOT)
  ) u_resolve (
    .valid_i      (in_valid_i),
    .ev_i         (ev),
    .pc_i         (in_pc_i),
    .tgt_i        (in_tgt_i),
    .seq_i        (in_seq_i),
    .pend_v_i     (pend_v_q),
    .pend_done_i  (pend_done_q),
    .pend_sq_i    (pend_sq_q),
    .pend_tgt_i   (pend_tgt_q),
    .pend_taken_i (pend_tk_q),
    .fwd_o        (fwd_d),
    .kill_o       (kill_d),
    .rv_o         (rv_d),
    .cerr_o       (cerr_d),
    .taken_o      (taken_d),
    .done_o       (done_d),
    .sq_o         (sq_d),
    .rpc_o        (rpc_d),
    .rnpc_o       (rnpc_d),
    .pend_v_o     (pend_v_d),
    .pend_done_o  (pend_done_d),
    .pend_sq_o    (pend_sq_d),
    .pend_tgt_o   (pend_tgt_d),
    .pend_taken_o (pend_tk_d),
    .n_res_o      (n_res),
    .mis_hit_o    (mis_hit),
    .cerr_hit_o   (cerr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0; pend_tk_q <= 1'b0;
      pend_done_q <= '0; pend_sq_q <= '0; pend_tgt_q <= '0;
      fwd_o <= '0; kill_o <= '0;
      redir_valid_o <= 1'b0; redir_taken_o <= 1'b0; ctrl_err_o <= 1'b0;
      redir_done_seq_o <= '0; redir_squash_seq_o <= '0;
      redir_pc_o <= '0; redir_npc_o <= '0;
    end else begin
      pend_v_q <= pend_v_d; pend_tk_q <= pend_tk_d;
      pend_done_q <= pend_done_d; pend_sq_q <= pend_sq_d; pend_tgt_q <= pend_tgt_d;
      fwd_o <= fwd_d; kill_o <= kill_d;
      redir_valid_o <= rv_d; redir_taken_o <= taken_d; ctrl_err_o <= cerr_d;
      redir_done_seq_o <= done_d; redir_squash_seq_o <= sq_d;
      redir_pc_o <= rpc_d; redir_npc_o <= rnpc_d;
    end
  end

  brx_counters #(.CNT_W(CNT_W), .NR_W(NR_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .n_res_i    (n_res),
    .mis_hit_i  (mis_hit),
    .cerr_hit_i (cerr_hit),
    .cnt_res_o  (cnt_resolved_o),
    .cnt_mis_o  (cnt_mispred_o),
    .cnt_ctrl_o (cnt_ctrl_o)
  );
endmodule

// File: rtl/brx_checker.sv
module brx_checker #(
  parameter int DECODE_W   = 4,
  parameter int SEQ_W      = 16,
  parameter int CNT_W      = 16,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DECODE_W-1:0] in_valid_i,
  input logic [DECODE_W-1:0] fwd_o,
  input logic [DECODE_W-1:0] kill_o,
  input logic                redir_valid_o,
  input logic [SEQ_W-1:0]    redir_done_seq_o,
  input logic [SEQ_W-1:0]    redir_squash_seq_o,
  input logic                ctrl_err_o,
  input logic [CNT_W-1:0]    cnt_ctrl_o
);
  a_r5_fwd_kill_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o & kill_o) == '0);

  a_r5_kill_needs_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|kill_o) |-> redir_valid_o);

  a_r4_fwd_only_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o & ~$past(in_valid_i)) == '0);

  a_r6_cerr_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_err_o |-> redir_valid_o);

  a_r8_squash_seq_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_o |-> (redir_squash_seq_o == redir_done_seq_o) ||
                      (redir_squash_seq_o == redir_done_seq_o + 1'b1));

  a_r7_no_defer_without_ds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_valid_o && !DELAY_SLOT) |-> redir_squash_seq_o == redir_done_seq_o);

  a_r9_ctrl_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_err_o |-> cnt_ctrl_o == $past(cnt_ctrl_o) + 1'b1);

  a_r9_ctrl_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_err_o |-> $stable(cnt_ctrl_o));
endmodule

bind brx_redirect_check brx_checker #(
  .DECODE_W(DECODE_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .DELAY_SLOT(DELAY_SLOT)
) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .in_valid_i         (in_valid_i),
  .fwd_o              (fwd_o),
  .kill_o             (kill_o),
  .redir_valid_o      (redir_valid_o),
  .redir_done_seq_o   (redir_done_seq_o),
  .redir_squash_seq_o (redir_squash_seq_o),
  .ctrl_err_o         (ctrl_err_o),
  .cnt_ctrl_o         (cnt_ctrl_o)
);

// File: tb/brx_redirect_check_test.sv
module brx_redirect_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  typedef struct packed {
    logic [3:0]  fwd;
    logic [3:0]  kill;
    logic        rv;
    logic        cerr;
    logic        taken;
    logic [15:0] done;
    logic [15:0] sq;
    logic [31:0] pc;
    logic [31:0] npc;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] d_v, d_c, d_d, d_u, d_pt, d_cd;
  logic [W-1:0][31:0] d_pc, d_tg, d_pp;
  logic [W-1:0][15:0] d_sq;
  logic [W-1:0] s_v, s_c, s_d, s_u, s_pt, s_cd;
  logic [W-1:0][31:0] s_pc, s_tg, s_pp;
  logic [W-1:0][15:0] s_sq;

  exp_t got0, got1;
  logic [15:0] cr0, cm0, cc0, cr1, cm1, cc1;

  brx_redirect_check #(.DELAY_SLOT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(d_v), .in_ctrl_i(d_c), .in_direct_i(d_d),
    .in_uncond_i(d_u), .in_pred_taken_i(d_pt), .in_cond_ds_i(d_cd), .in_pc_i(d_pc),
    .in_seq_i(d_sq), .in_tgt_i(d_tg), .in_pred_pc_i(d_pp),
    .fwd_o(got0.fwd), .kill_o(got0.kill), .redir_valid_o(got0.rv),
    .redir_done_seq_o(got0.done), .redir_squash_seq_o(got0.sq), .redir_pc_o(got0.pc),
    .redir_npc_o(got0.npc), .redir_taken_o(got0.taken), .ctrl_err_o(got0.cerr),
    .cnt_resolved_o(cr0), .cnt_mispred_o(cm0), .cnt_ctrl_o(cc0));

  brx_redirect_check #(.DELAY_SLOT(1'b1)) uut_ds (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(d_v), .in_ctrl_i(d_c), .in_direct_i(d_d),
    .in_uncond_i(d_u), .in_pred_taken_i(d_pt), .in_cond_ds_i(d_cd), .in_pc_i(d_pc),
    .in_seq_i(d_sq), .in_tgt_i(d_tg), .in_pred_pc_i(d_pp),
    .fwd_o(got1.fwd), .kill_o(got1.kill), .redir_valid_o(got1.rv),
    .redir_done_seq_o(got1.done), .redir_squash_seq_o(got1.sq), .redir_pc_o(got1.pc),
    .redir_npc_o(got1.npc), .redir_taken_o(got1.taken), .ctrl_err_o(got1.cerr),
    .cnt_resolved_o(cr1), .cnt_mispred_o(cm1), .cnt_ctrl_o(cc1));

  int checks = 0, errors = 0;
  exp_t q0[$], q1[$];
  string qt[$];

  task automatic chk_exp(string tag, string inst, exp_t g, exp_t e);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, inst, g, e);
    end
  endtask

  task automatic chk_val(string tag, logic [31:0] g, logic [31:0] e);
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, g, e);
    end
  endtask

  // monitor: outputs registered at the edge, sampled 1 time unit later
  always @(posedge clk) begin
    #1;
    if (q0.size() > 0) begin
      exp_t e0, e1;
      string t;
      e0 = q0.pop_front(); e1 = q1.pop_front(); t = qt.pop_front();
      chk_exp(t, "nods", got0, e0);
      chk_exp(t, "ds", got1, e1);
    end
  end

  function automatic exp_t none(logic [3:0] f);
    exp_t e = '0;
    e.fwd = f;
    return e;
  endfunction

  function automatic exp_t red(logic [3:0] f, logic [3:0] k, logic ce, logic tk,
                               logic [15:0] dn, logic [15:0] sq, logic [31:0] pc);
    exp_t e;
    e.fwd = f; e.kill = k; e.rv = 1'b1; e.cerr = ce; e.taken = tk;
    e.done = dn; e.sq = sq; e.pc = pc; e.npc = pc + 32'd4;
    return e;
  endfunction

  task automatic clr();
    s_v = '0; s_c = '0; s_d = '0; s_u = '0; s_pt = '0; s_cd = '0;
    s_pc = '0; s_tg = '0; s_pp = '0; s_sq = '0;
  endtask

  task automatic plain(int i, logic [31:0] pc, logic [15:0] sq);
    s_v[i] = 1'b1; s_pc[i] = pc; s_sq[i] = sq; s_pp[i] = pc + 32'd4;
  endtask

  task automatic br(int i, logic [31:0] pc, logic [15:0] sq, logic [31:0] tg,
                    logic [31:0] pp, logic cd);
    s_v[i] = 1'b1; s_c[i] = 1'b1; s_d[i] = 1'b1; s_u[i] = 1'b1;
    s_pc[i] = pc; s_sq[i] = sq; s_tg[i] = tg; s_pp[i] = pp;
    s_pt[i] = (pp != pc + 32'd4); s_cd[i] = cd;
  endtask

  // driver: apply a group at the falling edge and queue what each instance must show
  task automatic step(string tag, exp_t e0, exp_t e1);
    @(negedge clk);
    d_v = s_v; d_c = s_c; d_d = s_d; d_u = s_u; d_pt = s_pt; d_cd = s_cd;
    d_pc = s_pc; d_tg = s_tg; d_pp = s_pp; d_sq = s_sq;
    q0.push_back(e0); q1.push_back(e1); qt.push_back(tag);
    clr();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr();
    d_v = '0; d_c = '0; d_d = '0; d_u = '0; d_pt = '0; d_cd = '0;
    d_pc = '0; d_tg = '0; d_pp = '0; d_sq = '0;
    repeat (3) @(negedge clk);
    chk_exp("R1 reset", "nods", got0, '0);
    chk_exp("R1 reset", "ds", got1, '0);
    chk_val("R1 counters", {cr0, cr1}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) plain(i, 32'h100 + 32'(4 * i), 16'(10 + i));
    step("R4 plain group", none(4'b1111), none(4'b1111));

    plain(0, 32'h200, 14); br(1, 32'h204, 15, 32'h300, 32'h300, 1'b0);
    plain(2, 32'h300, 16); plain(3, 32'h304, 17);
    step("R3 correct branch", none(4'b1111), none(4'b1111));

    plain(0, 32'h400, 20); br(1, 32'h404, 21, 32'h800, 32'h408, 1'b0);
    plain(2, 32'h408, 22); plain(3, 32'h40c, 23);
    step("R3/R4/R5/R8 same-cycle slot",
         red(4'b0011, 4'b1100, 0, 0, 21, 21, 32'h800),
         red(4'b0111, 4'b1000, 0, 0, 21, 22, 32'h800));

    br(0, 32'h500, 30, 32'h600, 32'h700, 1'b1);
    plain(1, 32'h504, 31); plain(2, 32'h508, 32);
    step("R7 taken with cond slot",
         red(4'b0001, 4'b0110, 0, 1, 30, 30, 32'h600),
         red(4'b0001, 4'b0110, 0, 1, 30, 30, 32'h600));

    br(0, 32'h500, 33, 32'h600, 32'h700, 1'b0);
    plain(1, 32'h504, 34); plain(2, 32'h508, 35);
    step("R7/R8 taken, plain slot",
         red(4'b0001, 4'b0110, 0, 1, 33, 33, 32'h600),
         red(4'b0011, 4'b0100, 0, 1, 33, 34, 32'h600));

    plain(0, 32'h800, 40); plain(1, 32'h804, 41); plain(2, 32'h808, 42);
    br(3, 32'h80c, 43, 32'h900, 32'h810, 1'b0);
    step("R8 branch in last slot",
         red(4'b1111, 4'b0000, 0, 0, 43, 43, 32'h900), none(4'b1111));
    step("R8 pending over idle", none(4'b0000), none(4'b0000));
    plain(0, 32'h810, 44); plain(1, 32'h814, 45); plain(2, 32'h818, 46);
    step("R8 deferred redirect",
         none(4'b0111), red(4'b0001, 4'b0110, 0, 0, 43, 44, 32'h900));

    plain(0, 32'h1000, 50);
    s_v[1] = 1'b1; s_pc[1] = 32'h1004; s_sq[1] = 51; s_pt[1] = 1'b1; s_pp[1] = 32'h2000;
    plain(2, 32'h1008, 52);
    step("R6 non-control taken",
         red(4'b0011, 4'b0100, 1, 1, 51, 51, 32'h1008),
         red(4'b0011, 4'b0100, 1, 1, 51, 51, 32'h1008));

    br(1, 32'h3000, 60, 32'h3100, 32'h3004, 1'b0); plain(3, 32'h3004, 61);
    step("R4/R8 gap slot",
         red(4'b0010, 4'b1000, 0, 0, 60, 60, 32'h3100),
         red(4'b1010, 4'b0000, 0, 0, 60, 61, 32'h3100));

    s_v[0] = 1'b1; s_c[0] = 1'b1; s_u[0] = 1'b1; s_pt[0] = 1'b1;
    s_pc[0] = 32'h4000; s_sq[0] = 70; s_tg[0] = 32'h10; s_pp[0] = 32'h20;
    s_v[1] = 1'b1; s_c[1] = 1'b1; s_d[1] = 1'b1; s_pt[1] = 1'b1;
    s_pc[1] = 32'h20; s_sq[1] = 71; s_tg[1] = 32'h50; s_pp[1] = 32'h90;
    plain(2, 32'h90, 72);
    step("R2 unchecked controls", none(4'b0111), none(4'b0111));

    step("R5 idle drain", none(4'b0000), none(4'b0000));
    @(negedge clk);
    @(negedge clk);
    chk_val("R9 resolved nods", 32'(cr0), 6);
    chk_val("R9 resolved ds", 32'(cr1), 6);
    chk_val("R9 mispred nods", 32'(cm0), 5);
    chk_val("R9 mispred ds", 32'(cm1), 5);
    chk_val("R9 ctrl nods", 32'(cc0), 1);
    chk_val("R9 ctrl ds", 32'(cc1), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule